// File: doc/BRIEF.md
# Packed-Word Color Palette Loader

This block holds a 256-entry color lookup table of 24-bit RGB triplets and fills it from a 32-bit register bus. Software first loads a starting entry number into the index register and then writes palette data words. Each data word carries four consecutive component bytes of one continuous red, green, blue stream. A phase counter therefore follows the component position across word boundaries, so one word can finish one entry and begin the next. Entries are committed to palette storage when their blue byte arrives, and the entry index then advances by itself.

Four 32-bit registers sit in a small window: index, palette data, control and overlay. Only byte-address bits 4 to 2 are decoded, so the register set repeats every 32 bytes. A display-side lookup port returns the triplet for a pixel index one clock later.

Top module: `palette_loader`

## Requirements
- R1: After reset the entry index is 0, the component phase is red, the control and overlay registers read 0, the read data output is 0 and the lookup output is 0.
- R2: Within a data word, bits 31:24 are the earliest stream byte and bits 7:0 are the latest. The stream runs red, green, blue, and a stored entry appears on the lookup output as red in bits 23:16, green in 15:8 and blue in 7:0.
- R3: The component phase carries across data words. Red and green are held in staging until the matching blue byte arrives, and one word may commit up to two entries. From index 0 the words 0x11223344, 0x55667788 and 0x99AABBCC store 0x112233, 0x445566, 0x778899 and 0xAABBCC in entries 0 to 3.
- R4: Each committed entry advances the index by one, and the index wraps from 255 to 0.
- R5: A write to the index register (offset 0x00) loads bits 7:0 as the next entry, returns the phase to red and discards any staged red or green bytes.
- R6: Byte-address bits 4:2 select the register: 0 index, 1 palette data, 2 control, 3 overlay. All other address bits are ignored. Offsets 4 to 7 ignore writes and read as 0.
- R7: Control (offset 0x08) and overlay (offset 0x0C) are plain 32-bit storage. Writing them leaves the index, phase and staging untouched.
- R8: The lookup output shows the entry selected by the pixel index one clock after it is sampled. If that entry is written in the same clock, the output shows the old value.
- R9: A read of the index register returns the current entry index in bits 7:0, with zeros above, on the clock after the read strobe.
- R10: A read of the palette data register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pix_idx | input | 8 | Pixel index for lookup |
| pix_rgb | output | 24 | RGB triplet for the pixel index of the previous clock |

## Verification
On every cycle the assertions check that the decoder raises at most one write enable and none without a strobe. They also check the phase step of each data word, the index step that matches the number of commits, that the index holds when no palette word arrives, the index load, control storage, zero reads of the data register and that paired commits target distinct entries. Only the bench scenarios can show that the right bytes land in the right entries. This covers the byte order within a word, discarding of staged bytes, wrap at entry 255, aliasing across the window and the old-value result of a lookup that collides with a write, all checked against a reference model of the stream.

// File: rtl/palette_pkg.sv
package palette_pkg;
  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } comp_phase_e;

  typedef enum logic [2:0] {
    SEL_INDEX = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_OVL   = 3'd3
  } reg_sel_e;

  localparam int unsigned COMPONENTS = 3;
endpackage

// File: rtl/palette_regdec.sv
module palette_regdec
  import palette_pkg::*;
#(
  parameter int unsigned BUS_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  output logic              index_we,
  output logic              data_we,
  output logic              ctrl_we,
  output logic              ovl_we,
  output logic [2:0]        rd_sel
);
  logic [2:0] sel;
  logic       unused_addr_bits;

  assign sel              = bus_addr[4:2];
  assign unused_addr_bits = ^{bus_addr[BUS_AW-1:5], bus_addr[1:0], bus_rd};
  assign rd_sel           = sel;

  always_comb begin
    index_we = 1'b0;
    data_we  = 1'b0;
    ctrl_we  = 1'b0;
    ovl_we   = 1'b0;
    if (bus_wr) begin
      unique case (sel)
        SEL_INDEX: index_we = 1'b1;
        SEL_DATA:  data_we  = 1'b1;
        SEL_CTRL:  ctrl_we  = 1'b1;
        SEL_OVL:   ovl_we   = 1'b1;
        default:   ;
      endcase
    end
  end

  // R6: at most one register takes a write, and only under a strobe
  assert_onehot_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({index_we, data_we, ctrl_we, ovl_we}));
  assert_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> !(index_we || data_we || ctrl_we || ovl_we));
endmodule

// File: rtl/palette_stream.sv
module palette_stream
  import palette_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned RGB_W = COMPONENTS * COMP_W,
  localparam int unsigned BYTES = DATA_W / COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              index_we,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic              we_a,
  output logic [IDX_W-1:0]  wa_addr,
  output logic [RGB_W-1:0]  wa_data,
  output logic              we_b,
  output logic [IDX_W-1:0]  wb_addr,
  output logic [RGB_W-1:0]  wb_data
);
  comp_phase_e             phase_q, phase_d;
  logic [COMP_W-1:0]       stg_r_q, stg_r_d, stg_g_q, stg_g_d;
  logic [IDX_W-1:0]        idx_d;
  logic                    state_en;
  logic [COMP_W-1:0]       cur_byte;

  // next-state: walk the word's bytes from most to least significant
  always_comb begin
    phase_d  = phase_q;
    stg_r_d  = stg_r_q;
    stg_g_d  = stg_g_q;
    idx_d    = idx_q;
    we_a     = 1'b0;
    wa_addr  = '0;
    wa_data  = '0;
    we_b     = 1'b0;
    wb_addr  = '0;
    wb_data  = '0;
    cur_byte = '0;
    state_en = index_we || data_we;
    if (index_we) begin
      phase_d = PH_RED;
      stg_r_d = '0;
      stg_g_d = '0;
      idx_d   = wdata[IDX_W-1:0];
    end else if (data_we) begin
      for (int k = 0; k < BYTES; k++) begin
        cur_byte = wdata[DATA_W-1-k*COMP_W -: COMP_W];
        unique case (phase_d)
          PH_RED: begin
            stg_r_d = cur_byte;
            phase_d = PH_GREEN;
          end
          PH_GREEN: begin
            stg_g_d = cur_byte;
            phase_d = PH_BLUE;
          end
          default: begin
            if (!we_a) begin
              we_a    = 1'b1;
              wa_addr = idx_d;
              wa_data = {stg_r_d, stg_g_d, cur_byte};
            end else begin
              we_b    = 1'b1;
              wb_addr = idx_d;
              wb_data = {stg_r_d, stg_g_d, cur_byte};
            end
            idx_d   = idx_d + 1'b1;
            phase_d = PH_RED;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RED;
      stg_r_q <= '0;
      stg_g_q <= '0;
      idx_q   <= '0;
    end else if (state_en) begin
      phase_q <= phase_d;
      stg_r_q <= stg_r_d;
      stg_g_q <= stg_g_d;
      idx_q   <= idx_d;
    end
  end

  // R3: phase stays within red/green/blue
  assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);
  // R3: each data word moves the phase by the number of bytes it carries
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> int'(phase_q) == (int'($past(phase_q)) + BYTES) % COMPONENTS);
  // R4: index advances by exactly the number of commits
  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> idx_q == IDX_W'($past(idx_q) + IDX_W'($past(we_a)) + IDX_W'($past(we_b))));
  // R4, R7: without index or data writes the index holds
  assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_we || index_we) |=> $stable(idx_q) && $stable(phase_q));
  // R5: index load selects the entry and resets the phase
  assert_index_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    index_we |=> idx_q == $past(wdata[IDX_W-1:0]) && phase_q == PH_RED);
endmodule

// File: rtl/palette_ram.sv
module palette_ram #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned RGB_W = 24,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_a,
  input  logic [IDX_W-1:0] wa_addr,
  input  logic [RGB_W-1:0] wa_data,
  input  logic             we_b,
  input  logic [IDX_W-1:0] wb_addr,
  input  logic [RGB_W-1:0] wb_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [RGB_W-1:0] rd_data
);
  logic [RGB_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we_a) mem[wa_addr] <= wa_data;
    if (we_b) mem[wb_addr] <= wb_data;
  end

  // read of the array before this edge's writes land: old value on collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_addr];
  end

  // R3: two commits in one clock go to distinct entries
  assert_dual_write_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && we_b) |-> (wa_addr != wb_addr));
  // R3: port b is only used together with port a
  assert_b_needs_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_b |-> we_a);
endmodule

// File: rtl/palette_loader.sv
module palette_loader
  import palette_pkg::*;
#(
  parameter int unsigned BUS_AW = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned RGB_W = COMPONENTS * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [RGB_W-1:0]  pix_rgb
);
  logic              index_we, data_we, ctrl_we, ovl_we;
  logic [2:0]        rd_sel;
  logic [IDX_W-1:0]  idx_q;
  logic              we_a, we_b;
  logic [IDX_W-1:0]  wa_addr, wb_addr;
  logic [RGB_W-1:0]  wa_data, wb_data;
  logic [DATA_W-1:0] ctrl_q, ovl_q, rdata_d;

  palette_regdec #(.BUS_AW(BUS_AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .index_we(index_we), .data_we(data_we),
    .ctrl_we(ctrl_we), .ovl_we(ovl_we), .rd_sel(rd_sel)
  );

  palette_stream #(.DATA_W(DATA_W), .COMP_W(COMP_W), .IDX_W(IDX_W)) u_stream (
    .clk(clk), .rst_n(rst_n), .index_we(index_we), .data_we(data_we),
    .wdata(bus_wdata), .idx_q(idx_q),
    .we_a(we_a), .wa_addr(wa_addr), .wa_data(wa_data),
    .we_b(we_b), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  palette_ram #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we_a(we_a), .wa_addr(wa_addr), .wa_data(wa_data),
    .we_b(we_b), .wb_addr(wb_addr), .wb_data(wb_data),
    .rd_addr(pix_idx), .rd_data(pix_rgb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovl_q <= '0;
    else if (ovl_we) ovl_q <= bus_wdata;
  end

  always_comb begin
    unique case (rd_sel)
      SEL_INDEX: rdata_d = {{(DATA_W-IDX_W){1'b0}}, idx_q};
      SEL_CTRL:  rdata_d = ctrl_q;
      SEL_OVL:   rdata_d = ovl_q;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end

  // R7: control register captures the written word
  assert_ctrl_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_q == $past(bus_wdata));
  // R7: overlay keeps its value unless addressed
  assert_ovl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_we |=> $stable(ovl_q));
  // R10: palette data register reads as zero
  assert_data_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rd_sel == SEL_DATA) |=> bus_rdata == '0);
endmodule

// File: tb/test_palette_loader.sv
`timescale 1ns/1ps
module test_palette_loader;
  logic        clk;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx;
  logic [23:0] pix_rgb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [23:0] m_mem [256];
  bit          m_val [256];
  int          m_idx, m_ph;
  logic [7:0]  m_r, m_g;
  logic [31:0] m_ctrl, m_ovl;

  palette_loader i_palette_loader (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // byte address for register sel, aliased into window copy 'win', junk in bits 1:0
  function automatic logic [11:0] reg_addr(input int sel, input int win, input int low);
    return 12'((win % 128) * 32 + sel * 4 + (low % 4));
  endfunction

  function automatic logic [23:0] pack_rgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    return {r, g, b};
  endfunction

  task automatic model_data(input logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      b = w[31-8*k -: 8];
      if (m_ph == 0) begin m_r = b; m_ph = 1; end
      else if (m_ph == 1) begin m_g = b; m_ph = 2; end
      else begin
        m_mem[m_idx] = pack_rgb(m_r, m_g, b);
        m_val[m_idx] = 1;
        m_idx = (m_idx + 1) % 256;
        m_ph = 0;
      end
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a[4:2])
      3'd0: begin m_idx = int'(d[7:0]); m_ph = 0; m_r = '0; m_g = '0; end
      3'd1: model_data(d);
      3'd2: m_ctrl = d;
      3'd3: m_ovl = d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic look(input int i, output logic [23:0] v);
    @(negedge clk);
    pix_idx = 8'(i);
    @(negedge clk);
    v = pix_rgb;
  endtask

  task automatic check_entry(input string req, input int i);
    logic [23:0] v;
    look(i, v);
    check(req, {8'h0, v}, {8'h0, m_mem[i]});
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [23:0] v;
    void'($urandom(32'd20251));
    for (int i = 0; i < 256; i++) m_val[i] = 0;
    m_idx = 0; m_ph = 0; m_r = '0; m_g = '0; m_ctrl = '0; m_ovl = '0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; pix_idx = '0;
    repeat (3) @(negedge clk);
    check("R1 lookup after reset", {8'h0, pix_rgb}, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rst_n = 1'b1;

    bus_read(reg_addr(0, 0, 0), rd); check("R1 index after reset", rd, 32'h0);
    bus_read(reg_addr(2, 0, 0), rd); check("R1 control after reset", rd, 32'h0);
    bus_read(reg_addr(3, 0, 0), rd); check("R1 overlay after reset", rd, 32'h0);

    // R3, R2: straddling words from entry 0
    bus_write(reg_addr(1, 0, 0), 32'h11223344);
    bus_write(reg_addr(1, 0, 0), 32'h55667788);
    bus_write(reg_addr(1, 0, 0), 32'h99AABBCC);
    look(0, v); check("R2 entry0", {8'h0, v}, 32'h00112233);
    look(1, v); check("R3 entry1", {8'h0, v}, 32'h00445566);
    look(2, v); check("R3 entry2", {8'h0, v}, 32'h00778899);
    look(3, v); check("R3 entry3", {8'h0, v}, 32'h00AABBCC);
    bus_read(reg_addr(0, 0, 0), rd); check("R9 index after three words", rd, 32'd4);
    bus_read(reg_addr(1, 0, 0), rd); check("R10 data register read", rd, 32'h0);

    // R4: wrap from 255 to 0
    bus_write(reg_addr(0, 0, 0), 32'hFFFF_FFFF);
    bus_write(reg_addr(1, 0, 0), 32'h01020304);
    bus_read(reg_addr(0, 0, 0), rd); check("R4 index wrapped", rd, 32'd0);
    bus_write(reg_addr(1, 0, 0), 32'h05060708);
    look(255, v); check("R4 entry255", {8'h0, v}, 32'h00010203);
    look(0, v); check("R4 entry0 after wrap", {8'h0, v}, 32'h00040506);

    // R5: index write discards staged bytes
    bus_write(reg_addr(0, 0, 0), 32'd10);
    bus_write(reg_addr(1, 0, 0), 32'hA1A2A3A4);
    bus_write(reg_addr(0, 0, 0), 32'd20);
    bus_write(reg_addr(1, 0, 0), 32'hB1B2B3B4);
    look(20, v); check("R5 entry20 from fresh phase", {8'h0, v}, 32'h00B1B2B3);
    bus_read(reg_addr(0, 0, 0), rd); check("R5 index after reload", rd, 32'd21);

    // R6, R7: aliasing, reserved offsets, no side effects
    bus_write(reg_addr(2, 5, 3), 32'hCAFE0001);
    bus_write(reg_addr(3, 77, 1), 32'hBEEF0002);
    bus_write(reg_addr(5, 0, 0), 32'h00000033);
    bus_write(reg_addr(4, 3, 0), 32'h00000044);
    bus_read(reg_addr(2, 0, 0), rd); check("R6 control via alias", rd, 32'hCAFE0001);
    bus_read(reg_addr(3, 9, 2), rd); check("R6 overlay via alias", rd, 32'hBEEF0002);
    bus_read(reg_addr(6, 0, 0), rd); check("R6 reserved reads zero", rd, 32'h0);
    bus_read(reg_addr(0, 0, 0), rd); check("R7 index unchanged by control writes", rd, 32'd21);
    bus_write(reg_addr(1, 0, 0), 32'hC1C2C3C4);
    look(21, v); check("R7 phase unchanged by control writes", {8'h0, v}, 32'h00B4C1C2);

    // R8: lookup colliding with a commit returns the old value
    bus_write(reg_addr(0, 0, 0), 32'd40);
    bus_write(reg_addr(1, 0, 0), 32'h0A0B0C0D);
    bus_write(reg_addr(0, 0, 0), 32'd40);
    @(negedge clk);
    pix_idx = 8'd40; bus_wr = 1'b1; bus_addr = reg_addr(1, 0, 0); bus_wdata = 32'h1E1F2021;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R8 read-during-write old value", {8'h0, pix_rgb}, 32'h000A0B0C);
    model_data(32'h1E1F2021);
    @(negedge clk);
    check("R8 new value one clock later", {8'h0, pix_rgb}, 32'h001E1F20);

    // random mix against the model
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 2) bus_write(reg_addr(0, int'($urandom), int'($urandom)), $urandom);
      else if (op < 7) bus_write(reg_addr(1, int'($urandom), int'($urandom)), $urandom);
      else if (op == 7) bus_write(reg_addr(2 + int'($urandom % 6), int'($urandom), 0), $urandom);
      else if (op == 8) begin
        bus_read(reg_addr(0, int'($urandom), 0), rd); check("R9 random index", rd, 32'(m_idx));
        bus_read(reg_addr(2, 0, 0), rd); check("R7 random control", rd, m_ctrl);
        bus_read(reg_addr(3, 0, 0), rd); check("R7 random overlay", rd, m_ovl);
      end else begin
        int e;
        e = int'($urandom % 256);
        if (m_val[e]) check_entry("R3 random entry", e);
      end
    end
    for (int i = 0; i < 256; i++)
      if (m_val[i]) check_entry("R2 final sweep", i);

    done = 1;
    summary();
    $finish;
  end
endmodule